// File: doc/BRIEF.md
# Paged Program Counter

This block holds the fetch address of a small processor whose program memory is divided into 64-word pages, with four consecutive pages forming a 256-word group. On every instruction-cycle strobe it loads a new address chosen by a two-bit operation select. The operations are a plain increment, an increment for an instruction that is skipped, a jump inside the current page, and an indirect jump or table lookup inside the current four-page group. Between strobes the address holds.

Both jump kinds take their upper address bits from the counter after it has been incremented, not from the counter as it stands. This matters when the jump instruction sits at the last word of a page or group. An in-page jump in the last word of a page lands in the following page. A group-relative access in the last word of a group, such as 0x0FF, reaches the following group.

A skipped instruction is still fetched, and the counter steps over it exactly as it would for an executed one. Besides the fetch address, the block drives a combinational target output. This output shows the address the next strobe will load, so decode logic can use it for data lookups.

Top module: `paged_pc`

## Requirements
- R1: While reset (rst_n low) is held, and at the first sample after it is released, fetch_addr is 0x000, whatever the other inputs are.
- R2: When cyc_en is low at a clock edge, fetch_addr keeps its value.
- R3: Operation 2'b00 (increment) loads fetch_addr+1, counting straight across page and group boundaries (0x03F becomes 0x040).
- R4: The counter wraps from 0x7FF to 0x000 on increment.
- R5: Operation 2'b01 (in-page jump) loads {bits 10:6 of fetch_addr+1, offset[5:0]}; offset bits 7:6 have no effect.
- R6: An in-page jump at a page's last word (address bits 5:0 all ones) lands in the following page (0x03F with offset 0x05 gives 0x045), and one at 0x7FF lands in page 0.
- R7: Operation 2'b10 (group-relative indirect) loads {bits 10:8 of fetch_addr+1, offset[7:0]}.
- R8: A group-relative access at a group's last word (address bits 7:0 all ones, e.g. 0x0FF) reaches the following group (0x0FF with offset 0x12 gives 0x112).
- R9: Operation 2'b11 (skipped instruction) advances the counter exactly as an increment does.
- R10: The target output always equals the address that the next strobe with the present op_sel and offset will load, and fetch_addr takes that value after a strobed edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle strobe; the counter loads on edges where it is high |
| op_sel | input | 2 | Operation: 00 increment, 01 in-page jump, 10 group-relative, 11 skipped |
| offset | input | 8 | Jump or lookup offset; bits 5:0 for in-page, bits 7:0 for group-relative |
| fetch_addr | output | 11 | Current program fetch address |
| target | output | 11 | Address the next strobe will load |

## Verification
The bench drives the counter to the last word of a page and of several groups, and then issues both jump kinds there. A design that takes the page or group bits from the unincremented counter would jump back into the same page or group, so these checks would see the wrong upper bits. It also increments and jumps at 0x7FF. A counter that is too wide, or that saturates, would miss the wrap to 0x000. The checks on offset bits 7:6 during in-page jumps catch a design that lets them leak into the page number. The checks on held strobes and on the skip code catch a design that advances without a strobe or that treats a skipped instruction differently.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    PC_OP_INC   = 2'b00,
    PC_OP_PAGE  = 2'b01,
    PC_OP_GROUP = 2'b10,
    PC_OP_SKIP  = 2'b11
  } pc_op_e;
endpackage

// File: rtl/pc_incr.sv
module pc_incr #(
  parameter int ADDR_W  = 11,
  parameter int PAGE_W  = 6,
  parameter int GROUP_W = 8
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] pc_plus1,
  output logic              page_end,
  output logic              group_end
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    return a + ONE;
  endfunction

  assign pc_plus1  = bump(pc);
  assign page_end  = &pc[PAGE_W-1:0];
  assign group_end = &pc[GROUP_W-1:0];
endmodule

// File: rtl/pc_target_sel.sv
module pc_target_sel
  import pc_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int PAGE_W  = 6,
  parameter int GROUP_W = 8
) (
  input  logic [ADDR_W-1:0]  pc_plus1,
  input  pc_op_e             op,
  input  logic [GROUP_W-1:0] offset,
  output logic [ADDR_W-1:0]  target
);
  function automatic logic [ADDR_W-1:0] in_page(input logic [ADDR_W-1:0] base,
                                                input logic [GROUP_W-1:0] off);
    return {base[ADDR_W-1:PAGE_W], off[PAGE_W-1:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] in_group(input logic [ADDR_W-1:0] base,
                                                 input logic [GROUP_W-1:0] off);
    return {base[ADDR_W-1:GROUP_W], off};
  endfunction

  always_comb begin
    unique case (op)
      PC_OP_PAGE:  target = in_page(pc_plus1, offset);
      PC_OP_GROUP: target = in_group(pc_plus1, offset);
      default:     target = pc_plus1;
    endcase
  end
endmodule

// File: rtl/pc_state.sv
module pc_state #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/paged_pc.sv
module paged_pc
  import pc_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int PAGE_W  = 6,
  parameter int GROUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_en,
  input  logic [1:0]         op_sel,
  input  logic [GROUP_W-1:0] offset,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic [ADDR_W-1:0]  target
);
  logic [ADDR_W-1:0] pc_plus1;
  logic              page_end;
  logic              group_end;
  pc_op_e            op_e;

  assign op_e = pc_op_e'(op_sel);

  pc_incr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .GROUP_W(GROUP_W)) u_incr (
    .pc        (fetch_addr),
    .pc_plus1  (pc_plus1),
    .page_end  (page_end),
    .group_end (group_end)
  );

  pc_target_sel #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .GROUP_W(GROUP_W)) u_sel (
    .pc_plus1 (pc_plus1),
    .op       (op_e),
    .offset   (offset),
    .target   (target)
  );

  pc_state #(.ADDR_W(ADDR_W)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cyc_en),
    .d     (target),
    .q     (fetch_addr)
  );
endmodule

// File: rtl/paged_pc_chk.sv
module paged_pc_chk #(
  parameter int ADDR_W  = 11,
  parameter int PAGE_W  = 6,
  parameter int GROUP_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cyc_en,
  input logic [1:0]         op_sel,
  input logic [GROUP_W-1:0] offset,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic [ADDR_W-1:0]  target,
  input logic               page_end,
  input logic               group_end
);
  logic at_top;
  assign at_top = &fetch_addr;

  // R10
  next_is_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en |=> fetch_addr == $past(target));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(fetch_addr));

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b00 && !at_top) |-> target == fetch_addr + 1'b1);

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b00 && at_top) |-> target == '0);

  // R5
  page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 2'b01 |-> target[PAGE_W-1:0] == offset[PAGE_W-1:0]);

  // R6
  page_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b01 && page_end) |-> target[ADDR_W-1:PAGE_W] != fetch_addr[ADDR_W-1:PAGE_W]);

  // R7
  group_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 2'b10 |-> target[GROUP_W-1:0] == offset);

  // R8
  group_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 2'b10 && group_end) |-> target[ADDR_W-1:GROUP_W] != fetch_addr[ADDR_W-1:GROUP_W]);

  // R9
  skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && op_sel == 2'b11 && !at_top) |=> fetch_addr == $past(fetch_addr) + 1'b1);
endmodule

bind paged_pc paged_pc_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .GROUP_W(GROUP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_en     (cyc_en),
  .op_sel     (op_sel),
  .offset     (offset),
  .fetch_addr (fetch_addr),
  .target     (target),
  .page_end   (page_end),
  .group_end  (group_end)
);

// File: tb/paged_pc_tb.sv
`timescale 1ns/1ps
module paged_pc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_en = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [7:0]  offset = 8'h00;
  logic [10:0] fetch_addr;
  logic [10:0] target;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [10:0] model = 11'h000;

  always #4 clk = ~clk;

  paged_pc u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .op_sel(op_sel),
    .offset(offset), .fetch_addr(fetch_addr), .target(target)
  );

  function automatic logic [10:0] exp_next(input logic [10:0] pc,
                                           input logic [1:0] op,
                                           input logic [7:0] off);
    logic [10:0] nxt;
    nxt = (pc == 11'h7FF) ? 11'h000 : pc + 11'd1;
    if (op == 2'b01) return (nxt & 11'h7C0) | {5'd0, off[5:0]};
    if (op == 2'b10) return (nxt & 11'h700) | {3'd0, off};
    return nxt;
  endfunction

  task automatic chk(input string req, input logic [10:0] act, input logic [10:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic step(input logic [1:0] op, input logic [7:0] off,
                      input logic en, input string req);
    logic [10:0] e;
    op_sel = op; offset = off; cyc_en = en;
    #1;
    e = exp_next(model, op, off);
    chk({req, " / R10 target"}, target, e);
    @(posedge clk);
    if (en) model = e;
    @(negedge clk);
    chk(req, fetch_addr, model);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    // R1: reset holds zero even with a strobe and a jump requested
    cyc_en = 1'b1; op_sel = 2'b10; offset = 8'hA5;
    repeat (3) @(negedge clk);
    chk("R1 in reset", fetch_addr, 11'h000);
    rst_n = 1'b1; cyc_en = 1'b0;
    @(negedge clk);
    chk("R1 after release", fetch_addr, 11'h000);
    model = 11'h000;

    // R2: no strobe, no change
    step(2'b00, 8'h00, 1'b0, "R2 hold inc");
    step(2'b10, 8'h77, 1'b0, "R2 hold group");
    step(2'b00, 8'h00, 1'b1, "R3 inc");
    // reach 0x03F then cross the page
    step(2'b10, 8'h3E, 1'b1, "R7 group to 0x03E");
    step(2'b11, 8'h00, 1'b1, "R9 skip to 0x03F");
    chk("R9 skip address", fetch_addr, 11'h03F);
    step(2'b01, 8'hC5, 1'b1, "R6 page jump at 0x03F, R5 bits 7:6 ignored");
    chk("R6 lands in next page", fetch_addr, 11'h045);
    step(2'b10, 8'h3F, 1'b1, "R7 group to 0x03F");
    step(2'b00, 8'h00, 1'b1, "R3 inc across page");
    chk("R3 0x040", fetch_addr, 11'h040);
    step(2'b10, 8'hFF, 1'b1, "R7 group to 0x0FF");
    step(2'b10, 8'h12, 1'b1, "R8 group at 0x0FF");
    chk("R8 next group", fetch_addr, 11'h112);
    step(2'b01, 8'h3F, 1'b1, "R5 page jump 0x13F");
    step(2'b01, 8'h00, 1'b1, "R6 page jump 0x13F");
    chk("R6 lands 0x140", fetch_addr, 11'h140);
    // climb to 0x7FF through group ends
    step(2'b10, 8'hFF, 1'b1, "R7 group to 0x1FF");
    for (int g = 0; g < 6; g++) step(2'b10, 8'hFF, 1'b1, "R8 climb");
    chk("R8 reached top", fetch_addr, 11'h7FF);
    step(2'b00, 8'h00, 1'b1, "R4 wrap inc");
    chk("R4 wrapped", fetch_addr, 11'h000);
    step(2'b10, 8'hFF, 1'b1, "R7 group to 0x0FF");
    for (int g = 0; g < 7; g++) step(2'b10, 8'hFF, 1'b1, "R8 climb");
    step(2'b01, 8'h2A, 1'b1, "R6 page jump at 0x7FF");
    chk("R6 wraps to page 0", fetch_addr, 11'h02A);
    step(2'b10, 8'hFE, 1'b1, "R7 group to 0x0FE");
    step(2'b11, 8'h00, 1'b0, "R2 hold skip");
    step(2'b11, 8'h00, 1'b1, "R9 skip to 0x0FF");
    step(2'b11, 8'h00, 1'b1, "R9 skip across group");
    chk("R9 0x100", fetch_addr, 11'h100);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] rop;
      logic [7:0] roff;
      logic       ren;
      rop  = 2'($urandom);
      roff = 8'($urandom);
      ren  = ($urandom % 4) != 0;
      step(rop, roff, ren, "R10 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule